// File: doc/BRIEF.md
# Wrap-Pattern Burst Read Sequencer

This block sits between a host bus and a word-addressed memory array with a fixed one-cycle read. When the host pulses an address strobe while the chip is selected and synchronous operation is on, the block captures the start address. After a programmable initial latency, it streams array words to the host, one per clock. The word order wraps inside an aligned group of 8, 16 or 32 words. A ready output tells the host which cycles carry valid data.

A host-writable 9-bit setup register controls the block. Its fields are a 3-bit latency code (cfg[2:0], giving 2 to 9 cycles), a 2-bit group length (cfg[4:3]), an output-edge select (cfg[5]), the ready polarity (cfg[6]), an early-ready option (cfg[7]) and the synchronous enable (cfg[8]). Each captured address delivers at most 128 words. After that the block goes quiet until the host strobes a new address. Dropping chip select or output enable ends a burst at once, and a fresh strobe restarts the sequence from the new address.

Top module: `wrap_burst_reader`

## Requirements
- R1: Group length is cfg[4:3]: 00 gives 8 words, 01 gives 16, and 10 or 11 give 32. The i-th word issued is at address base + ((s - base + i) mod N), where s is the start address and base is s rounded down to a multiple of N.
- R2: Every word of a burst stays within the 64-word-aligned block of the start address. After the first word, one word is delivered on every clock with no gaps.
- R3: Exactly 128 words are delivered per captured address. Ready then stays inactive and no array read is issued until a new strobe.
- R4: Let k be the rising edge that captures the strobe. With latency code w = cfg[2:0], the first word (the array content at s) and ready become active after rising edge k + w + 2 + (s mod 2).
- R5: cfg[6] = 1 makes ready active-high; cfg[6] = 0 makes it active-low.
- R6: cfg[7] = 1 moves the whole ready waveform one clock earlier, so ready is active one cycle before the first word.
- R7: cfg[5] = 1 presents ready and data on the falling edge, half a clock after the rising-edge timing of R4. cfg[5] = 0 presents them right after the rising edge.
- R8: cfg[8] = 0 selects asynchronous mode. In this mode strobes are ignored, no array reads are issued and ready stays inactive.
- R9: If chip_en or out_en is low at a rising edge during a burst and no strobe is captured there, the burst ends at that edge. Ready is inactive after that edge, and no further reads occur until a new strobe.
- R10: A strobe captured during a burst drops ready and restarts the sequence and latency of R4 from the new address.
- R11: After reset the setup register is 0x040 (asynchronous, active-high ready, data-aligned ready, rising edge, latency code 0, 8-word groups). Ready is low and arr_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | CFG_W | Setup register write value |
| chip_en | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| addr_strobe | input | 1 | Address valid pulse |
| host_addr | input | ADDR_W | Start word address |
| arr_rd | output | 1 | Array read request |
| arr_addr | output | ADDR_W | Array word address |
| arr_data | input | DATA_W | Array read data, valid the cycle after arr_rd |
| host_data | output | DATA_W | Burst data to host |
| rdy | output | 1 | Data-valid indicator, polarity per cfg[6] |

## Verification
The first word is due w + 2 + (s mod 2) rising edges after the strobe edge. The remaining 127 words follow on consecutive edges, and ready must be inactive from edge L + 128 on. With the early option, the ready window starts and ends one edge sooner. The bench counts edges from the capturing edge and samples 2 ns after each rising edge, so every expectation is a function of that edge count. For falling-edge output it samples twice per cycle: at 2 ns it expects the previous cycle's ready, and at 7 ns the current one. Abort and restart are checked on the first edge after the triggering input changes, and then held for many cycles.

// File: rtl/wrap_burst_reader.sv
`timescale 1ns/1ps
module wrap_burst_reader #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CFG_W     = 9,
  parameter int MAX_WORDS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              arr_rd,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] host_data,
  output logic              rdy
);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(9'h040);

  typedef enum logic [1:0] {IDLE, LAT, RUN} st_t;

  logic [CFG_W-1:0]  cfg;
  st_t               st;
  logic [3:0]        lat_cnt;
  logic [ADDR_W-1:0] start_a;
  logic [4:0]        off, mask;
  logic [CNT_W-1:0]  issued;
  logic              vld_q;
  logic              neg_rdy;
  logic [DATA_W-1:0] neg_data;

  wire sync_en   = cfg[8];
  wire rdy_early = cfg[7];
  wire rdy_hi    = cfg[6];
  wire fall_edge = cfg[5];

  wire go   = addr_strobe && chip_en && sync_en;
  wire drop = (st != IDLE) && !(chip_en && out_en);

  assign arr_addr = {start_a[ADDR_W-1:5], (start_a[4:0] & ~mask) | (off & mask)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= CFG_RST;
      st      <= IDLE;
      lat_cnt <= '0;
      start_a <= '0;
      off     <= '0;
      mask    <= 5'd7;
      issued  <= '0;
      arr_rd  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      vld_q <= arr_rd;
      if (go) begin
        st      <= LAT;
        start_a <= host_addr;
        off     <= host_addr[4:0];
        mask    <= (cfg[4:3] == 2'b00) ? 5'd7 : (cfg[4:3] == 2'b01) ? 5'd15 : 5'd31;
        lat_cnt <= 4'(cfg[2:0]) + 4'(host_addr[0]);
        issued  <= '0;
        arr_rd  <= 1'b0;
        vld_q   <= 1'b0;
      end else if (drop) begin
        st     <= IDLE;
        issued <= '0;
        arr_rd <= 1'b0;
        vld_q  <= 1'b0;
      end else begin
        case (st)
          LAT: begin
            if (lat_cnt == 4'd0) begin
              st     <= RUN;
              arr_rd <= 1'b1;
              issued <= CNT_W'(1);
            end else begin
              lat_cnt <= lat_cnt - 4'd1;
            end
          end
          RUN: begin
            if (issued == CNT_W'(MAX_WORDS)) begin
              st     <= IDLE;
              arr_rd <= 1'b0;
            end else begin
              off    <= off + 5'd1;
              issued <= issued + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  wire rdy_int = rdy_early ? arr_rd : vld_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_rdy  <= 1'b0;
      neg_data <= '0;
    end else begin
      neg_rdy  <= rdy_int;
      neg_data <= arr_data;
    end
  end

  wire rdy_lvl = fall_edge ? neg_rdy : rdy_int;
  assign host_data = fall_edge ? neg_data : arr_data;
  assign rdy       = rdy_hi ? rdy_lvl : ~rdy_lvl;

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && $past(arr_rd) && $past(st == RUN) |->
      (arr_addr == $past(arr_addr) + ADDR_W'(1)) || (arr_addr == $past(arr_addr) - ADDR_W'(mask))); // R1
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && $past(arr_rd) |-> arr_addr[ADDR_W-1:6] == $past(arr_addr[ADDR_W-1:6])); // R2
  AST_WORD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    st == RUN && issued == CNT_W'(MAX_WORDS) && !go && !drop |=> !arr_rd); // R3
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(arr_rd)); // R4
  AST_ASYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en && st == IDLE |=> st == IDLE && !arr_rd); // R8
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !go |=> !vld_q && !arr_rd); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> st == LAT && !arr_rd && !vld_q); // R10
endmodule

// File: tb/test_wrap_burst_reader.sv
`timescale 1ns/1ps
module test_wrap_burst_reader;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, chip_en = 1, out_en = 1, addr_strobe = 0;
  logic [8:0]  cfg_wdata = '0;
  logic [15:0] host_addr = '0;
  logic        arr_rd, rdy;
  logic [15:0] arr_addr, arr_data, host_data;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wrap_burst_reader i_wrap_burst_reader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .chip_en(chip_en), .out_en(out_en), .addr_strobe(addr_strobe), .host_addr(host_addr),
    .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_data(arr_data),
    .host_data(host_data), .rdy(rdy));

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk) arr_data <= memf(arr_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cfg(input logic [8:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic strobe(input logic [15:0] a);
    @(negedge clk); addr_strobe = 1; host_addr = a;
    @(negedge clk); addr_strobe = 0;
  endtask

  function automatic bit win(input int c, input int lat, input bit early);
    return early ? (c >= lat - 1 && c <= lat + 126) : (c >= lat && c <= lat + 127);
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] s, input int n, input int i);
    logic [15:0] base;
    base = s & ~16'(n - 1);
    return base + 16'((int'(s - base) + i) % n);
  endfunction

  task automatic track(input int lat, input int n, input logic [15:0] s, input bit early,
                       input bit pol, input int ncyc, input string req);
    for (int c = 1; c <= ncyc; c++) begin
      bit e;
      @(posedge clk); #2;
      e = win(c, lat, early);
      check(rdy == (pol ? e : !e), {req, " rdy"}, rdy, pol ? e : !e);
      if (c >= lat && c <= lat + 127)
        check(host_data == memf(exp_addr(s, n, c - lat)), {req, " data"}, host_data,
              memf(exp_addr(s, n, c - lat)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(rdy == 1'b0, "R11 reset rdy", rdy, 0);
    check(arr_rd == 1'b0, "R11 reset arr_rd", arr_rd, 0);
    @(negedge clk); rst_n = 1;

    // R8 / R11: default configuration is asynchronous, strobe ignored
    strobe(16'h1234);
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); #2;
      check(rdy == 1'b0 && arr_rd == 1'b0, "R8 R11 default async", {rdy, arr_rd}, 0);
    end

    // R1 R2 R3 R4 sweep: lengths, latencies, start offsets
    for (int bl = 0; bl < 3; bl++) begin
      for (int w = 0; w < 8; w++) begin
        for (int si = 0; si < 4; si++) begin
          int n, o, lat;
          logic [15:0] s;
          n = 8 << bl;
          o = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? n / 2 + 2 : n - 1;
          s = 16'h1260 + 16'(o);
          lat = w + 2 + o % 2;
          wr_cfg({1'b1, 1'b0, 1'b1, 1'b0, 2'(bl), 3'(w)});
          strobe(s);
          track(lat, n, s, 0, 1, lat + 131, "R1 R2 R4 sweep");
          check(arr_rd == 1'b0, "R3 no read after cap", arr_rd, 0);
        end
      end
    end

    // R5 R6: active-low ready, early option
    wr_cfg({1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 3'd2});
    strobe(16'h1261);
    track(5, 16, 16'h1261, 1, 0, 136, "R5 R6 low early");

    // R7: falling-edge presentation
    wr_cfg({1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 3'd0});
    strobe(16'h1263);
    for (int c = 1; c <= 134; c++) begin
      @(posedge clk); #2;
      check(rdy == win(c - 1, 3, 0), "R7 rdy before fall", rdy, win(c - 1, 3, 0));
      #5;
      check(rdy == win(c, 3, 0), "R7 rdy after fall", rdy, win(c, 3, 0));
      if (win(c, 3, 0))
        check(host_data == memf(exp_addr(16'h1263, 8, c - 3)), "R7 data after fall",
              host_data, memf(exp_addr(16'h1263, 8, c - 3)));
    end

    // R9: abort by out_en
    wr_cfg({1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 3'd1});
    strobe(16'h1250);
    track(3, 8, 16'h1250, 0, 1, 7, "R9 pre-abort");
    @(negedge clk); out_en = 0;
    @(posedge clk); #2;
    check(rdy == 1'b0 && arr_rd == 1'b0, "R9 abort out_en", {rdy, arr_rd}, 0);
    @(negedge clk); out_en = 1;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); #2;
      check(rdy == 1'b0 && arr_rd == 1'b0, "R9 stays idle", {rdy, arr_rd}, 0);
    end

    // R9: abort by chip_en
    strobe(16'h1254);
    track(3, 8, 16'h1254, 0, 1, 5, "R9 pre-abort ce");
    @(negedge clk); chip_en = 0;
    @(posedge clk); #2;
    check(rdy == 1'b0 && arr_rd == 1'b0, "R9 abort chip_en", {rdy, arr_rd}, 0);
    @(negedge clk); chip_en = 1;
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); #2;
      check(rdy == 1'b0, "R9 stays idle ce", rdy, 0);
    end

    // R10: restart mid-burst
    wr_cfg({1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 3'd0});
    strobe(16'h1250);
    track(2, 8, 16'h1250, 0, 1, 5, "R10 first burst");
    strobe(16'h12A5);
    track(3, 8, 16'h12A5, 0, 1, 134, "R10 restarted burst");

    // R8: explicit async after sync use
    wr_cfg({1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 3'd0});
    strobe(16'h1300);
    for (int c = 0; c < 15; c++) begin
      @(posedge clk); #2;
      check(rdy == 1'b0 && arr_rd == 1'b0, "R8 async ignores strobe", {rdy, arr_rd}, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule